// File: doc/BRIEF.md
# Supervisory Tone Frequency Classifier

This block decides which of three permitted supervisory tone frequencies is present on a squared audio tone, or that none of them is. The tone arrives as a single asynchronous bit. It passes through a synchroniser and an edge detector, and every rising edge increments a counter. A free-running prescaler divides the system clock into fixed measurement windows. At the end of each window the accumulated edge count is compared against four boundary counts supplied on input ports, and the counter starts again from zero for the next window.

Boundary counts must be non-decreasing. They divide the count axis into five regions. Counts below the lowest boundary are not valid. Counts at or above the highest boundary are also not valid. The three regions in between stand for tones 1, 2 and 3. Each window produces a two-bit code on the output together with a one-cycle strobe. The code holds until the next strobe, so it can be read as a status field at any time. Choose the window length so that a fresh decision appears at least every 250 ms at the system clock rate in use.

Top module: `tone_bin_classifier`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `result_valid` is 0 and `tone_code` is 2'b00.
- R2: `result_valid` is high for exactly one cycle in each window. The first pulse follows the WIN_CYCLES-th rising clock edge after reset is released. Later pulses come every WIN_CYCLES cycles after that.
- R3: The count judged at each strobe equals the number of rising edges of `tone_in` that were seen, after a two-flop synchroniser, within that window only. Nothing carries over from an earlier window.
- R4: A count below `bound0` gives code 2'b00 (not valid).
- R5: A count with `bound0` <= count < `bound1` gives code 2'b01 (tone 1).
- R6: A count with `bound1` <= count < `bound2` gives code 2'b10 (tone 2).
- R7: A count with `bound2` <= count < `bound3` gives code 2'b11 (tone 3).
- R8: A count at or above `bound3` gives code 2'b00 (not valid).
- R9: The edge count saturates at 2^CNT_W-1 and does not wrap. A window with more edges than that is judged as the maximum count.
- R10: `tone_code` changes only in a cycle where `result_valid` is high.
- R11: The boundary ports are sampled only on the clock edge that closes a window. Their values at that edge decide the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_in | input | 1 | Squared supervisory tone, asynchronous |
| bound0 | input | CNT_W | Lowest count accepted as tone 1 |
| bound1 | input | CNT_W | Lowest count accepted as tone 2 |
| bound2 | input | CNT_W | Lowest count accepted as tone 3 |
| bound3 | input | CNT_W | Lowest count rejected as too high |
| tone_code | output | 2 | 00 not valid, 01 tone 1, 10 tone 2, 11 tone 3 |
| result_valid | output | 1 | One-cycle strobe when a new code is written |

## Verification
The bin properties assume that the boundary inputs are ordered `bound0` <= `bound1` <= `bound2` <= `bound3` at every window close. Otherwise the regions overlap and no code is well defined. The stimulus therefore changes boundaries only as an ordered set, directly after a strobe. It changes the tone period only in the same cycle, and it judges only the second window after a tone change, because the window that straddles the change mixes two patterns. Tone periods are picked to divide the window length, so each judged window holds an exact edge count that lands on, just below, or just above a boundary.

// File: rtl/tone_bin_pkg.sv
package tone_bin_pkg;

    localparam int NUM_BOUNDS = 4;

    typedef enum logic [1:0] {
        CODE_NONE  = 2'b00,
        CODE_TONE1 = 2'b01,
        CODE_TONE2 = 2'b10,
        CODE_TONE3 = 2'b11
    } tone_code_e;

    typedef struct packed {
        logic       valid;
        tone_code_e code;
    } tone_result_t;

    // ge[i] is set when the window count reaches boundary i
    function automatic tone_code_e code_from_flags(logic [NUM_BOUNDS-1:0] ge);
        tone_code_e c;
        if (ge[3])      c = CODE_NONE;
        else if (ge[2]) c = CODE_TONE3;
        else if (ge[1]) c = CODE_TONE2;
        else if (ge[0]) c = CODE_TONE1;
        else            c = CODE_NONE;
        return c;
    endfunction

endpackage

// File: rtl/tone_bin_sync.sv
module tone_bin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    // stages 0..STAGES-1 synchronise, stage STAGES holds the previous value
    logic [STAGES:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-1:0], din};
    end

    assign rise = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/tone_bin_window.sv
module tone_bin_window #(
    parameter int WIN_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

    logic [WIN_W-1:0] win_cnt;

    assign win_end = (win_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)          win_cnt <= '0;
        else if (win_end) win_cnt <= '0;
        else              win_cnt <= win_cnt + 1'b1;
    end
endmodule

// File: rtl/tone_bin_counter.sv
module tone_bin_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             win_end,
    output logic [CNT_W-1:0] edge_cnt,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

    // count including an edge that lands on the closing cycle
    always_comb begin
        if (rise && edge_cnt != MAXC) total = edge_cnt + 1'b1;
        else                          total = edge_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst || win_end) edge_cnt <= '0;
        else                edge_cnt <= total;
    end
endmodule

// File: rtl/tone_bin_decide.sv
module tone_bin_decide
    import tone_bin_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             win_end,
    input  logic [CNT_W-1:0]                 total,
    input  logic [NUM_BOUNDS-1:0][CNT_W-1:0] bounds,
    output tone_result_t                     result
);
    logic [NUM_BOUNDS-1:0] ge;

    for (genvar i = 0; i < NUM_BOUNDS; i++) begin : g_cmp
        assign ge[i] = (total >= bounds[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result.valid <= 1'b0;
            result.code  <= CODE_NONE;
        end else if (win_end) begin
            result.valid <= 1'b1;
            result.code  <= code_from_flags(ge);
        end else begin
            result.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tone_bin_classifier.sv
module tone_bin_classifier
    import tone_bin_pkg::*;
#(
    parameter int WIN_CYCLES = 1000,
    parameter int CNT_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tone_in,
    input  logic [CNT_W-1:0] bound0,
    input  logic [CNT_W-1:0] bound1,
    input  logic [CNT_W-1:0] bound2,
    input  logic [CNT_W-1:0] bound3,
    output logic [1:0]       tone_code,
    output logic             result_valid
);
    logic                             rise;
    logic                             win_end;
    logic [CNT_W-1:0]                 edge_cnt;
    logic [CNT_W-1:0]                 total;
    logic [NUM_BOUNDS-1:0][CNT_W-1:0] bounds;
    tone_result_t                     result;

    assign bounds = {bound3, bound2, bound1, bound0};

    tone_bin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (tone_in),
        .rise (rise)
    );

    tone_bin_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end)
    );

    tone_bin_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .win_end  (win_end),
        .edge_cnt (edge_cnt),
        .total    (total)
    );

    tone_bin_decide #(.CNT_W(CNT_W)) u_decide (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end),
        .total   (total),
        .bounds  (bounds),
        .result  (result)
    );

    assign tone_code    = result.code;
    assign result_valid = result.valid;
endmodule

// File: rtl/tone_bin_checker.sv
module tone_bin_checker #(
    parameter int WIN_CYCLES = 1000,
    parameter int CNT_W      = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] bound0,
    input logic [CNT_W-1:0] bound1,
    input logic [CNT_W-1:0] bound2,
    input logic [CNT_W-1:0] bound3,
    input logic [1:0]       tone_code,
    input logic             result_valid,
    input logic [CNT_W-1:0] edge_cnt,
    input logic [CNT_W-1:0] total,
    input logic             win_end
);
    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

    int since;

    always_ff @(posedge clk) begin
        if (rst)               since <= 0;
        else if (result_valid) since <= 1;
        else                   since <= since + 1;
    end

    // R1
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!result_valid && tone_code == 2'b00));

    // R2: strobe spacing counted in the checker
    p_period_r2: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (since == WIN_CYCLES));

    // R3: inside a window the count steps by at most one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(win_end) |-> ({1'b0, edge_cnt} == {1'b0, $past(edge_cnt)} ||
                             {1'b0, edge_cnt} == {1'b0, $past(edge_cnt)} + 1'b1));

    // R9
    p_sat_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(edge_cnt) == MAXC && !$past(win_end)) |-> (edge_cnt == MAXC));

    // R10
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(tone_code));

    // R4 and R8: not-valid code only outside the three bins
    p_none_r8: assert property (@(posedge clk) disable iff (rst)
        (result_valid && tone_code == 2'b00) |->
            ($past(total) < $past(bound0) || $past(total) >= $past(bound3)));

    p_tone1_r5: assert property (@(posedge clk) disable iff (rst)
        (result_valid && tone_code == 2'b01) |->
            ($past(total) >= $past(bound0) && $past(total) < $past(bound1)));

    p_tone2_r6: assert property (@(posedge clk) disable iff (rst)
        (result_valid && tone_code == 2'b10) |->
            ($past(total) >= $past(bound1) && $past(total) < $past(bound2)));

    p_tone3_r7: assert property (@(posedge clk) disable iff (rst)
        (result_valid && tone_code == 2'b11) |->
            ($past(total) >= $past(bound2) && $past(total) < $past(bound3)));
endmodule

bind tone_bin_classifier tone_bin_checker #(
    .WIN_CYCLES (WIN_CYCLES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bound0       (bound0),
    .bound1       (bound1),
    .bound2       (bound2),
    .bound3       (bound3),
    .tone_code    (tone_code),
    .result_valid (result_valid),
    .edge_cnt     (edge_cnt),
    .total        (total),
    .win_end      (win_end)
);

// File: tb/tone_bin_classifier_tb.sv
`timescale 1ns/1ps
module tone_bin_classifier_tb;
    localparam int W     = 400;
    localparam int CW    = 7;
    localparam int MAXC  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tone_in = 1'b0;
    logic [CW-1:0] bound0 = 7'd10;
    logic [CW-1:0] bound1 = 7'd20;
    logic [CW-1:0] bound2 = 7'd30;
    logic [CW-1:0] bound3 = 7'd40;
    logic [1:0]    tone_code;
    logic          result_valid;

    int checks = 0;
    int fails  = 0;
    int half   = 0;
    int phase  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_s1, m_s2, m_s3, m_win, m_cnt, m_code, m_valid;

    always #5 clk = ~clk;

    tone_bin_classifier #(.WIN_CYCLES(W), .CNT_W(CW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .tone_in      (tone_in),
        .bound0       (bound0),
        .bound1       (bound1),
        .bound2       (bound2),
        .bound3       (bound3),
        .tone_code    (tone_code),
        .result_valid (result_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int classify(input int c, input int b0, input int b1,
                                    input int b2, input int b3);
        if (c < b0)      return 0;
        else if (c < b1) return 1;
        else if (c < b2) return 2;
        else if (c < b3) return 3;
        else             return 0;
    endfunction

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        int e, t;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_win = 0; m_cnt = 0; m_code = 0; m_valid = 0;
        end else begin
            e = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
            t = (m_cnt + e > MAXC) ? MAXC : m_cnt + e;
            if (m_win == W - 1) begin
                m_code  = classify(t, int'(bound0), int'(bound1), int'(bound2), int'(bound3));
                m_valid = 1;
                m_cnt   = 0;
                m_win   = 0;
            end else begin
                m_valid = 0;
                m_cnt   = t;
                m_win   = m_win + 1;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(tone_in);
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done && !rst) begin
            check(int'(result_valid) == m_valid, "R2 strobe", int'(result_valid), m_valid);
            check(int'(tone_code) == m_code, "R3 code", int'(tone_code), m_code);
        end
    end

    // tone generator: square wave with the given half period, low when zero
    always @(negedge clk) begin
        if (half == 0) begin
            tone_in <= 1'b0;
            phase   <= 0;
        end else if (phase >= half - 1) begin
            tone_in <= ~tone_in;
            phase   <= 0;
        end else begin
            phase <= phase + 1;
        end
    end

    task automatic wait_valid();
        do @(negedge clk); while (!result_valid);
    endtask

    task automatic set_tone(input int period);
        half = period / 2;
        wait_valid();
        wait_valid();
    endtask

    task automatic set_bounds(input int a, input int b, input int c, input int d);
        bound0 = CW'(a); bound1 = CW'(b); bound2 = CW'(c); bound3 = CW'(d);
        wait_valid();
    endtask

    task automatic expect_code(input int exp, input string tag);
        check(int'(tone_code) == exp, tag, int'(tone_code), exp);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        check(result_valid == 1'b0, "R1 valid in reset", int'(result_valid), 0);
        check(tone_code == 2'b00, "R1 code in reset", int'(tone_code), 0);
        rst = 1'b0;
        @(negedge clk);
        check(result_valid == 1'b0 && tone_code == 2'b00, "R1 after release",
              int'({tone_code, result_valid}), 0);
        n = 1;
        while (!result_valid) begin @(negedge clk); n++; end
        check(n == W, "R2 first strobe delay", n, W);
        n = 0;
        do begin @(negedge clk); n++; end while (!result_valid);
        check(n == W, "R2 strobe spacing", n, W);
        @(negedge clk);
        check(result_valid == 1'b0, "R2 strobe width", int'(result_valid), 0);

        set_tone(80);  expect_code(0, "R4 five edges below bound0");
        set_tone(40);  expect_code(1, "R5 ten edges equal bound0");
        set_tone(20);  expect_code(2, "R6 twenty edges equal bound1");
        set_tone(12);  expect_code(3, "R7 about 33 edges");
        set_tone(10);  expect_code(0, "R8 forty edges equal bound3");

        set_tone(20);
        set_bounds(10, 21, 30, 40); expect_code(1, "R11 count one below bound1");
        set_bounds(12, 15, 19, 20); expect_code(0, "R8 count equal bound3");
        set_bounds(12, 15, 20, 21); expect_code(3, "R7 count equal bound2");
        set_bounds(21, 25, 30, 40); expect_code(0, "R4 count one below bound0");
        set_bounds(20, 25, 30, 40); expect_code(1, "R5 count equal bound0");

        set_tone(16);
        set_bounds(10, 20, 30, 40); expect_code(2, "R6 25 edges");
        set_bounds(0, 1, 30, 40);
        half = 0;
        wait_valid(); wait_valid();
        expect_code(1, "R3 window with no edges gives zero count");

        set_bounds(60, 70, 80, 127);
        set_tone(2);   expect_code(0, "R9 200 edges saturate at 127");
        set_bounds(60, 70, 80, 127); expect_code(0, "R9 still saturated");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2: watchdog expired, actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule